// File: doc/BRIEF.md
# Fractional-Step Reference Counter

This block keeps a 64-bit count that advances at a constant nominal rate of 6.144 MHz, whatever the frequency of the reference clock it runs on. A residue register adds a programmed step numerator on every reference cycle. Whenever the running sum reaches the programmed divisor, the block removes the divisor from the sum and raises the count by one. The count therefore advances on a fraction step/divisor of reference cycles. The count is never stopped or reloaded, and it wraps silently at 2^64.

Software sets the ratio through a small register port. The step numerator register is at offset 0x10 and the divisor register is at offset 0x14. Each holds a 12-bit field in bits [11:0]. Bits [31:12] of each register are stored and read back unchanged, so a read-modify-write of the low field keeps whatever else lives in the word. The ratios that give 6.144 MHz are:

- 4/25 at 38.4 MHz, which is also the reset setting
- 8/25 at 19.2 MHz
- 64/125 at 12 MHz
- 768/1625 at 13 MHz
- 384/1625 at 26 MHz
- 256/1125 at 27 MHz

Software should write the step first and the divisor second, because a divisor write restarts the fraction.

Top module: `ratio_step_counter`

## Requirements
- R1: After reset the count reads 0. The step register reads 0x0000_0004 and the divisor register reads 0x0000_0019.
- R2: Take the clock edge that captures a divisor write. Over the N edges after it, with step < divisor and divisor nonzero, the count rises by exactly floor(N·step/divisor).
- R3: On any clock edge the count either holds or rises by exactly one.
- R4: The clock edge that captures a divisor write clears the residue and does not advance the count, even if a carry was due on that edge.
- R5: While the divisor field is zero, the count holds.
- R6: While the step field is greater than or equal to a nonzero divisor field, the count rises by one on every edge.
- R7: Offsets 0x10 (step) and 0x14 (divisor) store all 32 written bits and read them back. Only bits [11:0] set the ratio, so bits [31:12] may hold any value without changing the rate.
- R8: A write to any other offset changes no register. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its frequency may vary |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| reg_wr | input | 1 | Write strobe, captured on the rising edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| count | output | 64 | Free-running count |

## Verification
A residue that is wrong by even one unit never shows up as a single bad count. It appears as a drift: the count runs one tick early or late against floor(N·step/divisor), and this becomes visible within one divisor period, at most 4095 reference cycles. The bench therefore measures the count over long windows after each ratio is programmed. Other faults show at the ports on the edge that triggers them: a missed residue clear on a divisor write, a carry taken on that same edge, or a divisor of zero that still lets the count move. Random ratios exercise carry patterns that the six fixed ratios never reach.

// File: rtl/ratio_step_pkg.sv
package ratio_step_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned STEP_OFS = 32'h10;
  localparam int unsigned DIV_OFS  = 32'h14;
  localparam int unsigned N_REGS   = 2;
endpackage

// File: rtl/ratio_step_regs.sv
module ratio_step_regs
  import ratio_step_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned FIELD_W  = 12,
  parameter int unsigned STEP_RST = 4,
  parameter int unsigned DIV_RST  = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic [FIELD_W-1:0]   step_f,
  output logic [FIELD_W-1:0]   div_f,
  output logic                 div_wr
);
  logic [REG_W-1:0] word_q [N_REGS];
  logic [N_REGS-1:0] hit;
  logic [N_REGS-1:0] wen;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam int unsigned OFS  = (i == 0) ? STEP_OFS : DIV_OFS;
    localparam int unsigned RSTV = (i == 0) ? STEP_RST : DIV_RST;

    assign hit[i] = (addr == ADDR_W'(OFS));
    assign wen[i] = wr & hit[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[i] <= REG_W'(RSTV);
      end else if (wen[i]) begin
        word_q[i] <= wdata;
      end
    end

    // R8: a register that is not addressed keeps its word
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wen[i] |=> $stable(word_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_REGS; k++) begin
      if (hit[k]) rdata = rdata | word_q[k];
    end
  end

  assign step_f = word_q[0][FIELD_W-1:0];
  assign div_f  = word_q[1][FIELD_W-1:0];
  assign div_wr = wen[1];
endmodule

// File: rtl/ratio_step_residue.sv
module ratio_step_residue #(
  parameter int unsigned FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] step,
  input  logic [FIELD_W-1:0] div,
  input  logic               div_wr,
  output logic               carry
);
  logic [FIELD_W-1:0] res_q;
  logic [FIELD_W-1:0] res_d;
  logic [FIELD_W:0]   sum;
  logic               div_zero;
  logic               saturated;

  assign sum       = {1'b0, res_q} + {1'b0, step};
  assign div_zero  = (div == '0);
  assign saturated = (step >= div);

  always_comb begin
    res_d = res_q;
    carry = 1'b0;
    if (div_wr) begin
      res_d = '0;
    end else if (div_zero) begin
      res_d = res_q;
    end else if (saturated) begin
      res_d = '0;
      carry = 1'b1;
    end else if (sum >= {1'b0, div}) begin
      res_d = sum[FIELD_W-1:0] - div;
      carry = 1'b1;
    end else begin
      res_d = sum[FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  // R4: residue is zero right after a divisor write
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (res_q == '0));

  // R2: residue stays below a nonzero divisor
  assert_res_below_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0) |-> (res_q < div));
endmodule

// File: rtl/ratio_step_count.sv
module ratio_step_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: never more than one step per edge
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/ratio_step_counter.sv
module ratio_step_counter
  import ratio_step_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned FIELD_W  = 12,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned STEP_RST = 4,
  parameter int unsigned DIV_RST  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic [FIELD_W-1:0] step_f;
  logic [FIELD_W-1:0] div_f;
  logic               div_wr;
  logic               carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ratio_step_regs #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .STEP_RST(STEP_RST), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .step_f(step_f), .div_f(div_f), .div_wr(div_wr)
  );

  ratio_step_residue #(.FIELD_W(FIELD_W)) u_res (
    .clk(clk), .rst_n(rst_i_n), .step(step_f), .div(div_f),
    .div_wr(div_wr), .carry(carry)
  );

  ratio_step_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .inc(carry), .cnt(count)
  );

  // R5: zero divisor freezes the count
  assert_zero_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (div_f == '0) |=> $stable(count));

  // R4: a divisor write edge never advances the count
  assert_div_write_no_step_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    div_wr |=> $stable(count));

  // R6: step at or above a nonzero divisor advances on every edge
  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((div_f != '0) && (step_f >= div_f) && !div_wr) |=> (count == $past(count) + ONE));
endmodule

// File: tb/ratio_step_counter_test.sv
`timescale 1ns/1ps
module ratio_step_counter_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] count;

  int n_checks;
  int n_bad;

  ratio_step_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint unsigned exp_ticks(longint unsigned n,
                                                longint unsigned s,
                                                longint unsigned d);
    return (n * s) / d;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rate_check(string req, int unsigned s, int unsigned d, int unsigned n);
    logic [63:0] c0;
    write_reg(8'h10, s);
    write_reg(8'h14, d);
    c0 = count;
    repeat (n) @(negedge clk);
    check64(req, count - c0, exp_ticks(n, s, d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] c0;
    int unsigned tbl_s [6];
    int unsigned tbl_d [6];
    n_checks = 0;
    n_bad    = 0;
    void'($urandom(32'h5EED_0611));
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check64("R1 count", count, 64'd0);
    read_reg(8'h10, rd); check64("R1 step reg", {32'd0, rd}, 64'h4);
    read_reg(8'h14, rd); check64("R1 div reg", {32'd0, rd}, 64'h19);

    // R2 fixed ratios
    tbl_s = '{4, 8, 64, 768, 384, 256};
    tbl_d = '{25, 25, 125, 1625, 1625, 1125};
    for (int i = 0; i < 6; i++) rate_check("R2 table", tbl_s[i], tbl_d[i], 3000 + i * 7);

    // R2 random ratios
    for (int i = 0; i < 8; i++) begin
      int unsigned d;
      int unsigned s;
      int unsigned n;
      d = 1 + ($urandom % 4095);
      s = $urandom % d;
      n = 200 + ($urandom % 3000);
      rate_check("R2 random", s, d, n);
    end

    // R4 divisor write on an edge where a carry is due
    write_reg(8'h10, 32'd1);
    write_reg(8'h14, 32'd2);
    @(negedge clk);
    c0 = count;
    write_reg(8'h14, 32'd3);
    check64("R4 no step on div write", count, c0);
    repeat (30) @(negedge clk);
    check64("R4 restart from zero residue", count - c0, 64'd10);

    // R5 zero divisor holds
    write_reg(8'h14, 32'd0);
    c0 = count;
    repeat (50) @(negedge clk);
    check64("R5 hold", count, c0);

    // R6 step above divisor
    write_reg(8'h10, 32'd7);
    write_reg(8'h14, 32'd5);
    c0 = count;
    repeat (40) @(negedge clk);
    check64("R6 every edge", count - c0, 64'd40);

    // R7 upper bits stored and ignored for the rate
    write_reg(8'h10, 32'hABCD_E000 | 32'd8);
    write_reg(8'h14, 32'h1234_5000 | 32'd25);
    c0 = count;
    repeat (500) @(negedge clk);
    check64("R7 rate with upper bits", count - c0, 64'd160);
    read_reg(8'h10, rd); check64("R7 step readback", {32'd0, rd}, 64'hABCD_E008);
    read_reg(8'h14, rd); check64("R7 div readback", {32'd0, rd}, 64'h1234_5019);

    // R8 unmapped offset
    write_reg(8'h18, 32'hFFFF_FFFF);
    read_reg(8'h18, rd); check64("R8 unmapped read", {32'd0, rd}, 64'd0);
    read_reg(8'h10, rd); check64("R8 step untouched", {32'd0, rd}, 64'hABCD_E008);
    read_reg(8'h14, rd); check64("R8 div untouched", {32'd0, rd}, 64'h1234_5019);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule